// File: doc/BRIEF.md
# Read Alignment Pattern Detector

This block watches the rising-edge byte of one read-data lane while the memory interface re-reads a known training burst. A running slot counter advances every clock cycle during the search. The detector looks for one of two fixed two-byte sequences on consecutive accepted beats. When it finds one, it freezes the counter, keeps the counter's value as the alignment result and raises a sticky completion flag. A controller combines that flag with the flags of the other lanes.

The two accepted sequences start on opposite columns of the training burst. Whether capture begins on an odd or an even column, one of them lines up, so the ambiguity is resolved in both cases. The input is a valid/ready stream. Ready is held high at all times. The block has no storage to fill, so it never applies back-pressure, and every cycle with valid high counts as one rising-edge sample. The slot counter, the result and the flag are plain status pins.

Top module: `rdalign_detect`

## Requirements
- R1: After reset, `cmp_done_o` is 0, `run_slot_o` is 0 and `align_slot_o` is 0. `align_slot_o` stays 0 for as long as `cmp_done_o` is low.
- R2: While `cmp_done_o` is low and no match occurs, `run_slot_o` rises by one on every clock cycle, whether or not a beat is valid. It wraps from 2^SLOT_W-1 to 0, so its bit 0 toggles on every cycle.
- R3: `rise_ready_o` is always 1. Every cycle with `rise_valid_i` high is consumed as one sample.
- R4: An accepted 0xAA followed by an accepted 0x99 on the next valid beat is a match. `cmp_done_o` is 1 in the cycle after the 0x99 beat, and `align_slot_o` then equals the `run_slot_o` value of the 0x99 beat's cycle.
- R5: An accepted 0x55 followed by an accepted 0x66 on the next valid beat is a match, with the same timing and result as R4.
- R6: Cycles with `rise_valid_i` low are not samples. They neither arm nor clear a pending first byte, and they cannot complete a match, whatever the data.
- R7: A valid beat that is not the expected second byte clears the pending state. If that beat is itself a first byte (0xAA or 0x55), it arms a new attempt. For example, 0xAA, 0x12, 0x99 does not match, while 0xAA, 0xAA, 0x99 does.
- R8: Crossed pairs do not match: 0xAA followed by 0x66, and 0x55 followed by 0x99.
- R9: Once `cmp_done_o` is 1, it stays 1, and `align_slot_o` and `run_slot_o` keep their values until reset, whatever data arrives.
- R10: The slot counter does not advance on the match beat. From the cycle after the match, `run_slot_o` equals `align_slot_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rise_data_i | input | DATA_W | Rising-edge byte of the lane |
| rise_valid_i | input | 1 | Beat on `rise_data_i` is a sample |
| rise_ready_o | output | 1 | Always high; no back-pressure |
| run_slot_o | output | SLOT_W | Running slot counter |
| align_slot_o | output | SLOT_W | Latched alignment slot |
| cmp_done_o | output | 1 | Sticky pattern-found flag |

## Verification
The bench builds the block with its default parameters: an 8-bit lane, a 2-bit slot counter and the two default byte pairs. The 2-bit counter wraps every four cycles, so the directed scenarios place matches in different slots, including the slot reached just after a wrap. They also show the frozen value against the bench's own cycle count. With the default pairs, the crossed-pair, broken-pair and idle-gap cases can each be driven in a few beats.

// File: rtl/rdalign_pkg.sv
package rdalign_pkg;
  // Lane width and number of accepted two-byte sequences
  localparam int unsigned LANE_W = 8;
  localparam int unsigned PAIRS  = 2;

  // Index 0: sequence starting on an even column; index 1: odd column
  localparam logic [PAIRS-1:0][LANE_W-1:0] LEAD_BYTES  = {8'h55, 8'hAA};
  localparam logic [PAIRS-1:0][LANE_W-1:0] TRAIL_BYTES = {8'h66, 8'h99};
endpackage

// File: rtl/rdalign_pair_matcher.sv
module rdalign_pair_matcher #(
  parameter int unsigned DATA_W = rdalign_pkg::LANE_W,
  parameter int unsigned NPAIR  = rdalign_pkg::PAIRS,
  parameter logic [NPAIR-1:0][DATA_W-1:0] LEAD  = rdalign_pkg::LEAD_BYTES,
  parameter logic [NPAIR-1:0][DATA_W-1:0] TRAIL = rdalign_pkg::TRAIL_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              beat_valid,
  output logic              hit_o
);
  logic [NPAIR-1:0] armed_q;
  logic [NPAIR-1:0] lead_eq;
  logic [NPAIR-1:0] trail_eq;

  // One comparator pair per accepted sequence
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign lead_eq[p]  = (beat_data == LEAD[p]);
    assign trail_eq[p] = (beat_data == TRAIL[p]);
  end

  // A second byte completes only the sequence whose first byte is pending
  assign hit_o = beat_valid && |(armed_q & trail_eq);

  // Pending first byte: updated only on samples; a non-matching
  // sample clears it unless it is itself a first byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= '0;
    end else if (beat_valid) begin
      armed_q <= hit_o ? '0 : lead_eq;
    end
  end
endmodule

// File: rtl/rdalign_slot_counter.sv
module rdalign_slot_counter #(
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  output logic [SLOT_W-1:0] slot_o
);
  logic [SLOT_W-1:0] slot_q;

  // Free-running per clock until held; wraps naturally at 2^SLOT_W
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (!hold_i) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/rdalign_result_hold.sv
module rdalign_result_hold #(
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SLOT_W-1:0] align_o,
  output logic              done_o
);
  logic [SLOT_W-1:0] align_q;
  logic              done_q;

  // First match wins; later matches are ignored until reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      align_q <= '0;
      done_q  <= 1'b0;
    end else if (hit_i && !done_q) begin
      align_q <= slot_i;
      done_q  <= 1'b1;
    end
  end

  assign align_o = align_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rdalign_detect.sv
module rdalign_detect #(
  parameter int unsigned DATA_W = rdalign_pkg::LANE_W,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned NPAIR  = rdalign_pkg::PAIRS,
  parameter logic [NPAIR-1:0][DATA_W-1:0] LEAD  = rdalign_pkg::LEAD_BYTES,
  parameter logic [NPAIR-1:0][DATA_W-1:0] TRAIL = rdalign_pkg::TRAIL_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rise_data_i,
  input  logic              rise_valid_i,
  output logic              rise_ready_o,
  output logic [SLOT_W-1:0] run_slot_o,
  output logic [SLOT_W-1:0] align_slot_o,
  output logic              cmp_done_o
);
  logic              hit;
  logic              done;
  logic [SLOT_W-1:0] slot;

  // Nothing is buffered, so every beat is taken
  assign rise_ready_o = 1'b1;

  rdalign_pair_matcher #(
    .DATA_W (DATA_W),
    .NPAIR  (NPAIR),
    .LEAD   (LEAD),
    .TRAIL  (TRAIL)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_data  (rise_data_i),
    .beat_valid (rise_valid_i),
    .hit_o      (hit)
  );

  // Counter stops on the match beat so it lands on the latched value
  rdalign_slot_counter #(
    .SLOT_W (SLOT_W)
  ) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (done | hit),
    .slot_o (slot)
  );

  rdalign_result_hold #(
    .SLOT_W (SLOT_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .slot_i  (slot),
    .align_o (align_slot_o),
    .done_o  (done)
  );

  assign run_slot_o = slot;
  assign cmp_done_o = done;
endmodule

// File: rtl/rdalign_detect_chk.sv
module rdalign_detect_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] rise_data_i,
  input logic              rise_valid_i,
  input logic [SLOT_W-1:0] run_slot_o,
  input logic [SLOT_W-1:0] align_slot_o,
  input logic              cmp_done_o
);
  localparam logic [DATA_W-1:0] B_AA = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] B_99 = DATA_W'(8'h99);
  localparam logic [DATA_W-1:0] B_55 = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] B_66 = DATA_W'(8'h66);

  // R1
  result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_done_o |-> align_slot_o == '0);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_done_o |=> (cmp_done_o || run_slot_o == SLOT_W'($past(run_slot_o) + 1'b1)));

  // R4
  pair_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rise_valid_i && rise_data_i == B_99 &&
     $past(rise_valid_i && rise_data_i == B_AA)) |=> cmp_done_o);

  // R5
  pair_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rise_valid_i && rise_data_i == B_66 &&
     $past(rise_valid_i && rise_data_i == B_55)) |=> cmp_done_o);

  // R8
  cross_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cmp_done_o && rise_valid_i && rise_data_i == B_66 &&
     $past(rise_valid_i && rise_data_i == B_AA)) |=> !cmp_done_o);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done_o |=> (cmp_done_o && $stable(align_slot_o) && $stable(run_slot_o)));

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_done_o) |-> (align_slot_o == $past(run_slot_o) && run_slot_o == align_slot_o));
endmodule

bind rdalign_detect rdalign_detect_chk #(
  .DATA_W (DATA_W),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rise_data_i  (rise_data_i),
  .rise_valid_i (rise_valid_i),
  .run_slot_o   (run_slot_o),
  .align_slot_o (align_slot_o),
  .cmp_done_o   (cmp_done_o)
);

// File: tb/rdalign_detect_tb_top.sv
module rdalign_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W = 2;
  localparam int NSLOT = 2 ** SLOT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        rise_data = '0;
  logic              rise_valid = 1'b0;
  logic              rise_ready;
  logic [SLOT_W-1:0] run_slot;
  logic [SLOT_W-1:0] align_slot;
  logic              cmp_done;

  int checks = 0;
  int errors = 0;
  int edges;
  int last_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench's own count of clock edges since reset release
  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  rdalign_detect #(.SLOT_W(SLOT_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_data_i  (rise_data),
    .rise_valid_i (rise_valid),
    .rise_ready_o (rise_ready),
    .run_slot_o   (run_slot),
    .align_slot_o (align_slot),
    .cmp_done_o   (cmp_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rise_valid = 1'b0;
    rise_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle of stimulus; records the slot the counter holds in that cycle
  task automatic beat(input logic [7:0] d, input logic v);
    rise_data = d;
    rise_valid = v;
    last_slot = edges % NSLOT;
    @(negedge clk);
    rise_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(8'h00, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done", cmp_done, 0);
    chk("R1 run", run_slot, 0);
    chk("R1 align", align_slot, 0);
    chk("R3 ready", rise_ready, 1);
  endtask

  task automatic t_counter();
    int prev;
    do_reset();
    prev = run_slot;
    for (int i = 0; i < 9; i++) begin
      beat(8'h3C, 1'b1);
      chk("R2 run", run_slot, edges % NSLOT);
      chk("R2 bit0 toggle", run_slot[0], (prev % 2) ^ 1);
      chk("R1 align while searching", align_slot, 0);
      prev = run_slot;
    end
    chk("R3 ready", rise_ready, 1);
  endtask

  task automatic t_match(input string req, input logic [7:0] a, input logic [7:0] b, input int pre);
    int s;
    do_reset();
    idle(pre);
    beat(8'h11, 1'b1);
    beat(a, 1'b1);
    chk({req, " not yet"}, cmp_done, 0);
    beat(b, 1'b1);
    s = last_slot;
    chk({req, " done"}, cmp_done, 1);
    chk({req, " align"}, align_slot, s);
    chk("R10 run frozen", run_slot, s);
    beat(8'hAA, 1'b1);
    beat(8'h99, 1'b1);
    beat(8'h55, 1'b1);
    beat(8'h66, 1'b1);
    idle(3);
    chk("R9 done held", cmp_done, 1);
    chk("R9 align held", align_slot, s);
    chk("R9 run held", run_slot, s);
  endtask

  task automatic t_gap();
    int s;
    do_reset();
    beat(8'hAA, 1'b1);
    beat(8'h12, 1'b0);
    beat(8'h99, 1'b0);
    chk("R6 invalid 0x99 ignored", cmp_done, 0);
    beat(8'h99, 1'b1);
    s = last_slot;
    chk("R6 pending survives gap", cmp_done, 1);
    chk("R6 align", align_slot, s);
    do_reset();
    beat(8'h55, 1'b1);
    beat(8'h66, 1'b0);
    beat(8'h12, 1'b1);
    beat(8'h66, 1'b1);
    chk("R6 invalid beat cannot complete", cmp_done, 0);
  endtask

  task automatic t_clear();
    int s;
    do_reset();
    beat(8'hAA, 1'b1);
    beat(8'h12, 1'b1);
    beat(8'h99, 1'b1);
    idle(1);
    chk("R7 cleared by other byte", cmp_done, 0);
    beat(8'h55, 1'b1);
    beat(8'hAA, 1'b1);
    beat(8'h99, 1'b1);
    s = last_slot;
    chk("R7 rearm by first byte", cmp_done, 1);
    chk("R7 align", align_slot, s);
    do_reset();
    beat(8'hAA, 1'b1);
    beat(8'hAA, 1'b1);
    beat(8'h99, 1'b1);
    chk("R7 repeated first byte", cmp_done, 1);
  endtask

  task automatic t_cross();
    do_reset();
    beat(8'hAA, 1'b1);
    beat(8'h66, 1'b1);
    beat(8'h55, 1'b1);
    beat(8'h99, 1'b1);
    beat(8'h99, 1'b1);
    idle(2);
    chk("R8 crossed pairs", cmp_done, 0);
    chk("R8 counter still running", run_slot, edges % NSLOT);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_counter();
    t_match("R4", 8'hAA, 8'h99, 0);
    t_match("R4", 8'hAA, 8'h99, 2);
    t_match("R5", 8'h55, 8'h66, 1);
    t_match("R5", 8'h55, 8'h66, 5);
    t_gap();
    t_clear();
    t_cross();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule